// File: doc/BRIEF.md
# Master-to-Frame Clock Ratio Detector

This block measures the number of master clock cycles in each period of an asynchronous frame (left/right) clock. It reports a 3-bit ratio code that digital audio datapaths use to select their clocking and filter timing. A 3-bit configuration field chooses between automatic detection and a forced ratio. A single mode flag marks filter-bypass operation. That mode allows only two ratios and offers no automatic detection.

The frame clock passes through a synchroniser. Each rising edge closes one period measurement on a saturating counter. The measurement is matched against the nominal ratios with a small tolerance. Three consecutive frames that agree assert the locked flag. A frame that matches nothing asserts the error flag, and so does a configuration that is not allowed in the current mode. In both cases the last good code stays on the output.

Top module: `ratio_detector`

## Requirements
- R1: With mode flag 0 and configuration 000 (automatic), a measured period within tolerance of 128, 192, 256, 384, 512 or 768 master cycles reports code 1, 2, 3, 4, 5 or 6. The output changes on the master edge that follows detection of the synchronised rising frame edge.
- R2: With mode flag 0 and configuration 1 to 6, the output code equals the configured code one master cycle later. The error flag is set by any measured frame outside the window of that code's nominal period (128, 192, 256, 384, 512, 768).
- R3: With mode flag 0, configuration 111 is reserved. From the next cycle the error flag is 1 and locked is 0, and the output code holds its previous value. The output code is never 111.
- R4: With mode flag 1, configuration 001 forces 512 and 010 forces 768 master cycles per frame. Configurations 000 and 011 to 111 are illegal: they set the error flag, clear locked and hold the code.
- R5: A measured count matches a ratio only within plus or minus 2 of its nominal value. A count 3 or more away sets the error flag and keeps the last valid code.
- R6: Locked asserts once 3 consecutive measured frames agree on the same ratio. The partial period before the first rising edge after reset is not measured. Locked never coexists with the error flag.
- R7: Locked drops on the first frame that mismatches, and in automatic mode also on the first frame that matches a different ratio.
- R8: The period counter saturates at 2^12-1 and does not wrap. A frame clock that stalls longer than that range yields an error, even when the wrapped count would look like a valid ratio.
- R9: After reset the code is 000, locked is 0 and the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Frame clock, asynchronous to clk_m |
| cfg_ratio | input | 3 | Configured ratio code, 000 = automatic in normal mode |
| bypass_mode | input | 1 | 1 = filter-bypass mode |
| ratio_code | output | 3 | Effective ratio code |
| locked | output | 1 | Three consecutive agreeing frames seen |
| ratio_err | output | 1 | Illegal configuration or unmatched frame |

## Verification
The bench targets periods exactly 2 and 3 counts off nominal. A window that is one count too wide or too narrow flips the error flag on one of them. It swaps the configuration between modes, so that a classifier ignoring the mode flag would take code 001 as 128 cycles in bypass, or accept automatic detection there. A stall of 4352 cycles is chosen because a wrapping counter would read it as a clean 256 ratio and stay silent. Changes of ratio in automatic mode show whether the lock run is restarted or wrongly carried over.

// File: rtl/ratio_det_pkg.sv
package ratio_det_pkg;
   localparam int CODE_W = 3;
   typedef logic [CODE_W-1:0] rcode_t;

   // Nominal master cycles per frame for a code; 0 marks no ratio.
   function automatic int unsigned nominal(input rcode_t c, input logic byp);
      int unsigned n;
      n = 0;
      if (byp) begin
         case (c)
            3'd1: n = 512;
            3'd2: n = 768;
            default: n = 0;
         endcase
      end else begin
         case (c)
            3'd1: n = 128;
            3'd2: n = 192;
            3'd3: n = 256;
            3'd4: n = 384;
            3'd5: n = 512;
            3'd6: n = 768;
            default: n = 0;
         endcase
      end
      return n;
   endfunction

   function automatic logic in_window(input int unsigned m, input int unsigned nom,
                                      input int unsigned tol);
      return (nom != 0) && (m + tol >= nom) && (m <= nom + tol);
   endfunction
endpackage

// File: rtl/fclk_sync.sv
module fclk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fclk_sync needs at least two stages");
      end
   endgenerate

   // sh[STAGES-1] is the synchronised level, sh[STAGES] its one-cycle delay.
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], din};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/period_counter.sv
module period_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic [CNT_W-1:0] count,
   output logic             frame_evt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         armed <= 1'b0;
      end else if (rise) begin
         count <= CNT_W'(1);
         armed <= 1'b1;
      end else if (count != CNT_MAX) begin
         count <= count + CNT_W'(1);
      end
   end

   // The first edge after reset only starts a measurement.
   assign frame_evt = rise & armed;
endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
   import ratio_det_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int TOL   = 2
) (
   input  rcode_t           cfg,
   input  logic             bypass,
   input  logic [CNT_W-1:0] meas,
   output logic             cfg_bad,
   output logic             manual,
   output rcode_t           det,
   output logic             hit
);
   localparam int NCODES = 6;

   logic [NCODES:1] win;
   rcode_t          auto_det;
   logic            man_hit;

   generate
      for (genvar k = 1; k <= NCODES; k++) begin : g_win
         localparam int unsigned NOM = nominal(rcode_t'(k), 1'b0);
         assign win[k] = in_window(32'(meas), NOM, TOL);
      end
   endgenerate

   always_comb begin
      auto_det = '0;
      for (int k = NCODES; k >= 1; k--) begin
         if (win[k]) auto_det = rcode_t'(k);
      end
   end

   always_comb begin
      if (bypass) cfg_bad = (cfg != 3'd1) && (cfg != 3'd2);
      else        cfg_bad = (cfg == 3'd7);
   end

   assign manual  = (cfg != 3'd0);
   assign man_hit = in_window(32'(meas), nominal(cfg, bypass), TOL);
   assign det     = manual ? cfg : auto_det;
   assign hit     = manual ? man_hit : (auto_det != 3'd0);
endmodule

// File: rtl/ratio_detector.sv
module ratio_detector
   import ratio_det_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int TOL         = 2,
   parameter int LOCK_FRAMES = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_m,
   input  logic       rst_n,
   input  logic       frame_clk,
   input  logic [2:0] cfg_ratio,
   input  logic       bypass_mode,
   output logic [2:0] ratio_code,
   output logic       locked,
   output logic       ratio_err
);
   localparam int RUN_W = $clog2(LOCK_FRAMES + 1);
   localparam logic [RUN_W-1:0] RUN_LOCK = RUN_W'(LOCK_FRAMES);

   generate
      if ((2 ** CNT_W) - 1 <= 768 + TOL) begin : g_bad_cnt
         $error("CNT_W too small for the longest ratio");
      end
      if (LOCK_FRAMES < 1) begin : g_bad_lock
         $error("LOCK_FRAMES must be at least 1");
      end
   endgenerate

   logic             rise;
   logic             frame_evt;
   logic [CNT_W-1:0] period_cnt;
   logic             cfg_bad;
   logic             manual;
   rcode_t           det;
   logic             hit;

   rcode_t           code_q;
   rcode_t           prev_q;
   logic [RUN_W-1:0] run_q;
   logic             err_q;

   fclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_m),
      .rst_n (rst_n),
      .din   (frame_clk),
      .rise  (rise)
   );

   period_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk_m),
      .rst_n     (rst_n),
      .rise      (rise),
      .count     (period_cnt),
      .frame_evt (frame_evt)
   );

   ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
      .cfg     (cfg_ratio),
      .bypass  (bypass_mode),
      .meas    (period_cnt),
      .cfg_bad (cfg_bad),
      .manual  (manual),
      .det     (det),
      .hit     (hit)
   );

   always_ff @(posedge clk_m or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         prev_q <= '0;
         run_q  <= '0;
         err_q  <= 1'b0;
      end else if (cfg_bad) begin
         err_q <= 1'b1;
         run_q <= '0;
      end else begin
         if (manual) code_q <= cfg_ratio;
         if (frame_evt) begin
            if (hit) begin
               if (run_q != '0 && det == prev_q) begin
                  if (run_q != RUN_LOCK) run_q <= run_q + RUN_W'(1);
               end else begin
                  run_q <= RUN_W'(1);
               end
               prev_q <= det;
               err_q  <= 1'b0;
               if (!manual) code_q <= det;
            end else begin
               run_q <= '0;
               err_q <= 1'b1;
            end
         end
      end
   end

   assign ratio_code = code_q;
   assign locked     = (run_q == RUN_LOCK);
   assign ratio_err  = err_q;
endmodule

// File: rtl/ratio_detector_chk.sv
module ratio_detector_chk #(
   parameter int CNT_W = 12
) (
   input logic             clk_m,
   input logic             rst_n,
   input logic [2:0]       cfg_ratio,
   input logic             bypass_mode,
   input logic [2:0]       ratio_code,
   input logic             locked,
   input logic             ratio_err,
   input logic [CNT_W-1:0] period_cnt
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic illegal;
   assign illegal = bypass_mode ? !(cfg_ratio == 3'd1 || cfg_ratio == 3'd2)
                                : (cfg_ratio == 3'd7);

   // R3 and R4: an illegal setting flags an error and clears lock
   a_r4_bad_cfg: assert property (@(posedge clk_m) disable iff (!rst_n)
      illegal |=> (ratio_err && !locked));

   // R2: a legal forced code appears on the output one cycle later
   a_r2_forced_code: assert property (@(posedge clk_m) disable iff (!rst_n)
      (!illegal && cfg_ratio != 3'd0) |=> (ratio_code == $past(cfg_ratio)));

   // R3: the reserved code is never reported
   a_r3_no_reserved: assert property (@(posedge clk_m) disable iff (!rst_n)
      ratio_code != 3'd7);

   // R6: lock and error are exclusive
   a_r6_lock_clean: assert property (@(posedge clk_m) disable iff (!rst_n)
      locked |-> !ratio_err);

   // R8: the period counter holds at its ceiling or restarts, never wraps
   a_r8_saturate: assert property (@(posedge clk_m) disable iff (!rst_n)
      (period_cnt == CMAX) |=> (period_cnt == CMAX || period_cnt == CNT_W'(1)));
endmodule

bind ratio_detector ratio_detector_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_m       (clk_m),
   .rst_n       (rst_n),
   .cfg_ratio   (cfg_ratio),
   .bypass_mode (bypass_mode),
   .ratio_code  (ratio_code),
   .locked      (locked),
   .ratio_err   (ratio_err),
   .period_cnt  (period_cnt)
);

// File: tb/sim_ratio_detector.sv
`timescale 1ns/1ps
module sim_ratio_detector;
   localparam int CMAX = 4095;

   logic       clk_m = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_clk = 1'b0;
   logic [2:0] cfg_ratio = 3'd0;
   logic       bypass_mode = 1'b0;
   logic [2:0] ratio_code;
   logic       locked;
   logic       ratio_err;

   int checks = 0;
   int errors = 0;
   string cur_req = "R9";

   always #2 clk_m = ~clk_m;

   ratio_detector u0 (
      .clk_m       (clk_m),
      .rst_n       (rst_n),
      .frame_clk   (frame_clk),
      .cfg_ratio   (cfg_ratio),
      .bypass_mode (bypass_mode),
      .ratio_code  (ratio_code),
      .locked      (locked),
      .ratio_err   (ratio_err)
   );

   // Expected nominal periods, from the requirement text.
   function automatic int b_nom(input int c, input bit byp);
      if (byp) return (c == 1) ? 512 : (c == 2) ? 768 : 0;
      case (c)
         1: return 128;
         2: return 192;
         3: return 256;
         4: return 384;
         5: return 512;
         6: return 768;
         default: return 0;
      endcase
   endfunction

   function automatic bit b_near(input int m, input int nom);
      int d;
      d = m - nom;
      return (nom != 0) && (d <= 2) && (d >= -2);
   endfunction

   // Behavioural reference model
   int m_q[$];
   int m_cnt, m_code, m_run, m_prev;
   bit m_armed, m_err;

   task automatic m_accept(input int det, input bit autom);
      if (m_run != 0 && det == m_prev) begin
         if (m_run < 3) m_run++;
      end else m_run = 1;
      m_prev = det;
      m_err = 0;
      if (autom) m_code = det;
   endtask

   always @(posedge clk_m or negedge rst_n) begin
      if (!rst_n) begin
         m_q = {0, 0, 0};
         m_cnt = 0; m_code = 0; m_run = 0; m_prev = 0;
         m_armed = 0; m_err = 0;
      end else begin
         bit rise, evt, bad;
         int meas, det;
         rise = (m_q[1] == 1) && (m_q[2] == 0);
         evt = rise && m_armed;
         meas = m_cnt;
         if (rise) begin m_cnt = 1; m_armed = 1; end
         else if (m_cnt < CMAX) m_cnt++;
         bad = bypass_mode ? (cfg_ratio != 1 && cfg_ratio != 2) : (cfg_ratio == 7);
         if (bad) begin
            m_err = 1; m_run = 0;
         end else if (cfg_ratio != 0) begin
            m_code = cfg_ratio;
            if (evt) begin
               if (b_near(meas, b_nom(cfg_ratio, bypass_mode))) m_accept(cfg_ratio, 0);
               else begin m_run = 0; m_err = 1; end
            end
         end else if (evt) begin
            det = 0;
            for (int k = 1; k <= 6; k++) if (b_near(meas, b_nom(k, 0))) det = k;
            if (det != 0) m_accept(det, 1);
            else begin m_run = 0; m_err = 1; end
         end
         m_q.push_front(int'(frame_clk));
         void'(m_q.pop_back());
      end
   end

   always @(negedge clk_m) begin
      if (rst_n) begin
         checks++;
         if (ratio_code !== 3'(m_code) || locked !== (m_run == 3) || ratio_err !== m_err) begin
            errors++;
            $display("FAIL %s model: code=%0d lock=%0b err=%0b expected code=%0d lock=%0b err=%0b",
                     cur_req, ratio_code, locked, ratio_err, m_code, (m_run == 3), m_err);
         end
      end
   end

   task automatic expect_out(input string req, input int code, input bit lk, input bit er);
      checks++;
      if (ratio_code !== 3'(code) || locked !== lk || ratio_err !== er) begin
         errors++;
         $display("FAIL %s: code=%0d lock=%0b err=%0b expected code=%0d lock=%0b err=%0b",
                  req, ratio_code, locked, ratio_err, code, lk, er);
      end
   endtask

   task automatic frames(input int p, input int n);
      for (int i = 0; i < n; i++) begin
         frame_clk = 1'b1;
         repeat (p / 2) @(negedge clk_m);
         frame_clk = 1'b0;
         repeat (p - p / 2) @(negedge clk_m);
      end
   endtask

   task automatic set_cfg(input int c, input bit byp);
      cfg_ratio = 3'(c);
      bypass_mode = byp;
      repeat (2) @(negedge clk_m);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk_m);
      rst_n = 1'b1;
      @(negedge clk_m);
      expect_out("R9", 0, 0, 0);

      cur_req = "R1";
      frames(256, 5);
      expect_out("R6", 3, 1, 0);
      frames(384, 2);
      expect_out("R7", 4, 0, 0);
      frames(384, 4);
      expect_out("R1", 4, 1, 0);
      frames(128, 5);  expect_out("R1", 1, 1, 0);
      frames(192, 5);  expect_out("R1", 2, 1, 0);
      frames(512, 5);  expect_out("R1", 5, 1, 0);
      frames(768, 5);  expect_out("R1", 6, 1, 0);

      cur_req = "R5";
      frames(258, 5);  expect_out("R5", 3, 1, 0);
      frames(254, 4);  expect_out("R5", 3, 1, 0);
      frames(259, 1);
      frames(256, 1);  expect_out("R5", 3, 0, 1);
      frames(253, 1);
      frames(256, 1);  expect_out("R7", 3, 0, 1);
      frames(256, 4);  expect_out("R6", 3, 1, 0);

      cur_req = "R2";
      set_cfg(5, 0);
      expect_out("R2", 5, 1, 0);
      frames(512, 5);  expect_out("R2", 5, 1, 0);
      set_cfg(1, 0);
      expect_out("R2", 1, 1, 0);
      frames(512, 2);  expect_out("R2", 1, 0, 1);

      cur_req = "R3";
      set_cfg(7, 0);
      expect_out("R3", 1, 0, 1);
      frames(128, 3);  expect_out("R3", 1, 0, 1);

      cur_req = "R4";
      set_cfg(1, 1);
      frames(512, 5);  expect_out("R4", 1, 1, 0);
      set_cfg(2, 1);
      frames(768, 5);  expect_out("R4", 2, 1, 0);
      set_cfg(0, 1);
      expect_out("R4", 2, 0, 1);
      frames(768, 2);  expect_out("R4", 2, 0, 1);
      set_cfg(3, 1);
      expect_out("R4", 2, 0, 1);

      cur_req = "R8";
      set_cfg(0, 0);
      frames(256, 5);  expect_out("R8", 3, 1, 0);
      frames(4352, 1);
      frames(256, 1);  expect_out("R8", 3, 0, 1);
      frames(256, 4);  expect_out("R8", 3, 1, 0);

      repeat (4) @(negedge clk_m);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule